// File: doc/BRIEF.md
# Descriptor-Chained Multi-Lane SPI Controller

This block is an SPI controller that carries out a complete chip-select transaction by walking a table of sixteen transfer descriptors. Each descriptor picks how many data pins the transfer uses (one, two or four), whether bytes are driven out of the transmit FIFO, whether sampled bytes go into the receive FIFO, the transfer unit size, the number of units, and which descriptor comes next. One descriptor can drive a command on one pin. The next can issue tri-stated dummy clocks on two pins. A third can read data on two pins. All three run under a single chip-select assertion.

Software or a DMA engine fills the descriptor table and the transmit FIFO, issues a start pulse and later reads the receive FIFO. The serial clock follows SPI mode 0. Each half period of the clock lasts a programmable number of system clocks. When the transmit FIFO runs dry or the receive FIFO fills up, the controller holds the serial clock low at the next byte boundary. Sticky done and program-error bits are cleared by writing 1. Each has its own interrupt enable.

Top module: `spi_desc_master`

## Requirements
- R1: A descriptor is 27 bits wide. Its fields are: lane code [1:0], transmit enable [2], receive enable [3], unit code [5:4], unit count [20:6], next index [24:21], last flag [25] and close flag [26]. A start runs descriptor 0 first and then follows the next index of each descriptor. It stops after the first descriptor whose last flag is set, and it skips any entry that the chain does not reach. sts_done stays 0 until that last descriptor has finished.
- R2: Lane code 0 selects one lane: transmit on io[0] and receive on io[1]. Code 1 selects two lanes, io[1:0], and code 2 selects four lanes, io[3:0]. Bytes move MSB first. On two lanes, io[1] carries the higher bit of each pair. On four lanes, bits [7:4] go out on the first clock.
- R3: Unit code 0 selects 1-byte units, code 1 selects 4-byte units and code 2 selects 16-byte units. A descriptor moves unit count × unit size bytes, and each byte takes 8/lanes serial clocks.
- R4: A descriptor with transmit disabled keeps io_oe low on every lane but still produces its serial clocks. For example, 2 one-byte units at two lanes give 8 dummy clocks.
- R5: The serial clock idles low. Each low phase and each high phase lasts clk_div+1 system clocks. Input data is sampled on the rising edge.
- R6: spi_cs_n goes low on start. After the last descriptor, it rises only if that descriptor's close flag is set. Otherwise it stays low.
- R7: A transmitting descriptor that finds the TX FIFO empty at a byte boundary holds the serial clock low until a byte arrives.
- R8: A receiving descriptor that finds the RX FIFO full at a byte boundary holds the serial clock low until a byte is popped.
- R9: When a descriptor carries lane code 3 or unit code 3, sts_perr is set, the transaction ends, chip select is released and sts_done is not set.
- R10: A stop pulse aborts a running transaction in the next cycle. Chip select is released, busy drops and sts_done stays 0.
- R11: A FIFO-clear pulse empties both FIFOs. tx_dreq is high whenever the TX FIFO is not full, and rx_dreq is high whenever the RX FIFO holds data.
- R12: sts_clr[0] clears sts_done and sts_clr[1] clears sts_perr. If a set and a clear of the same bit fall in the same cycle, the set wins.
- R13: irq is high when sts_done is set with irq_en[0] high, or when sts_perr is set with irq_en[1] high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| desc_we | input | 1 | Descriptor table write strobe |
| desc_idx | input | 4 | Descriptor entry to write |
| desc_wdata | input | 27 | Descriptor contents |
| clk_div | input | 8 | Half-period length minus one, in system clocks |
| irq_en | input | 2 | Interrupt enables: [0] done, [1] program error |
| cmd_start | input | 1 | Start pulse |
| cmd_stop | input | 1 | Abort pulse |
| cmd_fifo_clr | input | 1 | Empty both FIFOs |
| sts_clr | input | 2 | Write-1 clear of done [0] and program error [1] |
| tx_wr | input | 1 | TX FIFO push |
| tx_wdata | input | 8 | TX FIFO byte |
| tx_full | output | 1 | TX FIFO full |
| tx_empty | output | 1 | TX FIFO empty |
| tx_dreq | output | 1 | TX FIFO can accept a byte |
| rx_rd | input | 1 | RX FIFO pop |
| rx_rdata | output | 8 | RX FIFO head byte |
| rx_empty | output | 1 | RX FIFO empty |
| rx_dreq | output | 1 | RX FIFO holds a byte |
| busy | output | 1 | Transaction in progress |
| sts_done | output | 1 | Sticky done |
| sts_perr | output | 1 | Sticky program error |
| irq | output | 1 | Interrupt request |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_io_out | output | 4 | Data lane output values |
| spi_io_oe | output | 4 | Data lane output enables |
| spi_io_in | input | 4 | Data lane inputs |

## Verification
A clear of the program-error bit can land in the same cycle in which the controller sets it on a bad descriptor. The bench provokes this by raising the start pulse and, one cycle later, holding sts_clr[1] high across the edge on which the illegal entry is fetched. It then expects sts_perr to read 1, because the set wins. A second, isolated clear must then bring it to 0.

// File: rtl/spi_desc_pkg.sv
package spi_desc_pkg;

    localparam int DESC_W  = 27;
    localparam int UNIT_W  = 15;
    localparam int NEXT_W  = 4;

    typedef struct packed {
        logic              close_cs;
        logic              last;
        logic [NEXT_W-1:0] next_idx;
        logic [UNIT_W-1:0] units;
        logic [1:0]        usize;
        logic              rx_en;
        logic              tx_en;
        logic [1:0]        lanes;
    } desc_t;

    localparam logic [1:0] LANE_X1 = 2'd0;
    localparam logic [1:0] LANE_X2 = 2'd1;
    localparam logic [1:0] LANE_X4 = 2'd2;
    localparam logic [1:0] CODE_BAD = 2'd3;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOAD,
        S_BYTE,
        S_LO,
        S_HI,
        S_NEXT
    } eng_st_e;

endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t   p_d, p_q;
    logic [W-1:0] mem [DEPTH];
    logic   do_push, do_pop;

    assign full    = (p_q.cnt == CW'(DEPTH));
    assign empty   = (p_q.cnt == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign rdata   = mem[p_q.rp];

    always_comb begin
        p_d = p_q;
        if (flush) begin
            p_d = '0;
        end else begin
            if (do_push) p_d.wp = (p_q.wp == AW'(DEPTH - 1)) ? '0 : p_q.wp + 1'b1;
            if (do_pop)  p_d.rp = (p_q.rp == AW'(DEPTH - 1)) ? '0 : p_q.rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   p_d.cnt = p_q.cnt + 1'b1;
                2'b01:   p_d.cnt = p_q.cnt - 1'b1;
                default: p_d.cnt = p_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[p_q.wp] <= wdata;
    end

endmodule

// File: rtl/spi_desc_table.sv
module spi_desc_table
    import spi_desc_pkg::*;
#(
    parameter int NDESC = 16,
    parameter int IDXW  = $clog2(NDESC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [IDXW-1:0] widx,
    input  desc_t           wdata,
    input  logic [IDXW-1:0] ridx,
    output desc_t           rdata
);
    desc_t tbl [NDESC];

    for (genvar g = 0; g < NDESC; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          tbl[g] <= '0;
            else if (we && widx == IDXW'(g))     tbl[g] <= wdata;
        end
    end

    assign rdata = tbl[ridx];

endmodule

// File: rtl/spi_desc_engine.sv
module spi_desc_engine
    import spi_desc_pkg::*;
#(
    parameter int DIVW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stop,
    input  logic [1:0]        clr_sts,
    input  logic [DIVW-1:0]   clk_div,
    output logic [NEXT_W-1:0] desc_ridx,
    input  desc_t             desc_rd,
    input  logic              tx_empty,
    output logic              tx_pop,
    input  logic [7:0]        tx_byte,
    input  logic              rx_full,
    output logic              rx_push,
    output logic [7:0]        rx_byte,
    output logic              sclk,
    output logic              cs_n,
    output logic [3:0]        io_out,
    output logic [3:0]        io_oe,
    input  logic [3:0]        io_in,
    output logic              busy,
    output logic              done,
    output logic              perr
);
    localparam int BYTEW = UNIT_W + 4;

    typedef struct packed {
        eng_st_e           st;
        logic [NEXT_W-1:0] idx;
        desc_t             cur;
        logic [BYTEW-1:0]  bytes;
        logic [3:0]        clks;
        logic [DIVW-1:0]   div;
        logic [7:0]        txsh;
        logic [7:0]        rxsh;
        logic              cs_n;
        logic              done;
        logic              perr;
    } eng_t;

    localparam eng_t RST = '{st: S_IDLE, idx: '0, cur: '0, bytes: '0, clks: '0,
                             div: '0, txsh: '0, rxsh: '0, cs_n: 1'b1,
                             done: 1'b0, perr: 1'b0};

    eng_t q, n;
    logic [7:0]       sampled;
    logic [BYTEW-1:0] load_bytes;
    logic             stall;

    assign load_bytes = BYTEW'(desc_rd.units) << {desc_rd.usize, 1'b0};
    assign stall      = (q.cur.tx_en && tx_empty) || (q.cur.rx_en && rx_full);

    always_comb begin
        case (q.cur.lanes)
            LANE_X2: sampled = {q.rxsh[5:0], io_in[1:0]};
            LANE_X4: sampled = {q.rxsh[3:0], io_in[3:0]};
            default: sampled = {q.rxsh[6:0], io_in[1]};
        endcase
    end

    always_comb begin
        n       = q;
        tx_pop  = 1'b0;
        rx_push = 1'b0;
        if (clr_sts[0]) n.done = 1'b0;
        if (clr_sts[1]) n.perr = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (start) begin
                    n.st   = S_LOAD;
                    n.idx  = '0;
                    n.cs_n = 1'b0;
                end
            end
            S_LOAD: begin
                n.cur = desc_rd;
                if (desc_rd.lanes == CODE_BAD || desc_rd.usize == CODE_BAD) begin
                    n.perr = 1'b1;
                    n.cs_n = 1'b1;
                    n.st   = S_IDLE;
                end else begin
                    n.bytes = load_bytes;
                    n.st    = (load_bytes == '0) ? S_NEXT : S_BYTE;
                end
            end
            S_BYTE: begin
                if (!stall) begin
                    tx_pop = q.cur.tx_en;
                    n.txsh = q.cur.tx_en ? tx_byte : 8'h00;
                    n.clks = 4'd8 >> q.cur.lanes;
                    n.div  = '0;
                    n.st   = S_LO;
                end
            end
            S_LO: begin
                if (q.div == clk_div) begin
                    n.div  = '0;
                    n.rxsh = sampled;
                    n.st   = S_HI;
                end else begin
                    n.div = q.div + 1'b1;
                end
            end
            S_HI: begin
                if (q.div == clk_div) begin
                    n.div = '0;
                    case (q.cur.lanes)
                        LANE_X2: n.txsh = {q.txsh[5:0], 2'b00};
                        LANE_X4: n.txsh = {q.txsh[3:0], 4'b0000};
                        default: n.txsh = {q.txsh[6:0], 1'b0};
                    endcase
                    n.clks = q.clks - 1'b1;
                    if (q.clks == 4'd1) begin
                        rx_push = q.cur.rx_en;
                        n.bytes = q.bytes - 1'b1;
                        n.st    = (q.bytes == BYTEW'(1)) ? S_NEXT : S_BYTE;
                    end else begin
                        n.st = S_LO;
                    end
                end else begin
                    n.div = q.div + 1'b1;
                end
            end
            S_NEXT: begin
                if (q.cur.last) begin
                    n.done = 1'b1;
                    if (q.cur.close_cs) n.cs_n = 1'b1;
                    n.st = S_IDLE;
                end else begin
                    n.idx = q.cur.next_idx;
                    n.st  = S_LOAD;
                end
            end
            default: n.st = S_IDLE;
        endcase
        if (stop) begin
            n.st    = S_IDLE;
            n.cs_n  = 1'b1;
            tx_pop  = 1'b0;
            rx_push = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST;
        else        q <= n;
    end

    always_comb begin
        io_out = 4'b0000;
        io_oe  = 4'b0000;
        case (q.cur.lanes)
            LANE_X2: begin io_out = {2'b00, q.txsh[7:6]}; io_oe = 4'b0011; end
            LANE_X4: begin io_out = q.txsh[7:4];          io_oe = 4'b1111; end
            default: begin io_out = {3'b000, q.txsh[7]};  io_oe = 4'b0001; end
        endcase
        if (!((q.st == S_LO || q.st == S_HI) && q.cur.tx_en)) io_oe = 4'b0000;
    end

    assign desc_ridx = q.idx;
    assign rx_byte   = q.rxsh;
    assign sclk      = (q.st == S_HI);
    assign cs_n      = q.cs_n;
    assign busy      = (q.st != S_IDLE);
    assign done      = q.done;
    assign perr      = q.perr;

endmodule

// File: rtl/spi_desc_master.sv
module spi_desc_master
    import spi_desc_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int DIVW       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_we,
    input  logic [NEXT_W-1:0] desc_idx,
    input  logic [DESC_W-1:0] desc_wdata,
    input  logic [DIVW-1:0]   clk_div,
    input  logic [1:0]        irq_en,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic              cmd_fifo_clr,
    input  logic [1:0]        sts_clr,
    input  logic              tx_wr,
    input  logic [7:0]        tx_wdata,
    output logic              tx_full,
    output logic              tx_empty,
    output logic              tx_dreq,
    input  logic              rx_rd,
    output logic [7:0]        rx_rdata,
    output logic              rx_empty,
    output logic              rx_dreq,
    output logic              busy,
    output logic              sts_done,
    output logic              sts_perr,
    output logic              irq,
    output logic              spi_sclk,
    output logic              spi_cs_n,
    output logic [3:0]        spi_io_out,
    output logic [3:0]        spi_io_oe,
    input  logic [3:0]        spi_io_in
);
    localparam int NDESC = 1 << NEXT_W;

    logic [NEXT_W-1:0] ridx;
    desc_t             rdesc;
    logic              tx_pop, rx_push, rx_full;
    logic [7:0]        tx_head, rx_byte;

    spi_desc_table #(.NDESC(NDESC), .IDXW(NEXT_W)) u_table (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (desc_we),
        .widx  (desc_idx),
        .wdata (desc_t'(desc_wdata)),
        .ridx  (ridx),
        .rdata (rdesc)
    );

    spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (cmd_fifo_clr),
        .push  (tx_wr),
        .wdata (tx_wdata),
        .pop   (tx_pop),
        .rdata (tx_head),
        .full  (tx_full),
        .empty (tx_empty)
    );

    spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (cmd_fifo_clr),
        .push  (rx_push),
        .wdata (rx_byte),
        .pop   (rx_rd),
        .rdata (rx_rdata),
        .full  (rx_full),
        .empty (rx_empty)
    );

    spi_desc_engine #(.DIVW(DIVW)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (cmd_start),
        .stop      (cmd_stop),
        .clr_sts   (sts_clr),
        .clk_div   (clk_div),
        .desc_ridx (ridx),
        .desc_rd   (rdesc),
        .tx_empty  (tx_empty),
        .tx_pop    (tx_pop),
        .tx_byte   (tx_head),
        .rx_full   (rx_full),
        .rx_push   (rx_push),
        .rx_byte   (rx_byte),
        .sclk      (spi_sclk),
        .cs_n      (spi_cs_n),
        .io_out    (spi_io_out),
        .io_oe     (spi_io_oe),
        .io_in     (spi_io_in),
        .busy      (busy),
        .done      (sts_done),
        .perr      (sts_perr)
    );

    assign tx_dreq = !tx_full;
    assign rx_dreq = !rx_empty;
    assign irq     = (sts_done && irq_en[0]) || (sts_perr && irq_en[1]);

endmodule

// File: rtl/spi_desc_master_chk.sv
module spi_desc_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_stop,
    input logic       cmd_fifo_clr,
    input logic       busy,
    input logic       spi_sclk,
    input logic       spi_cs_n,
    input logic [3:0] spi_io_oe,
    input logic       sts_done,
    input logic       sts_perr,
    input logic       tx_empty,
    input logic       rx_empty
);
    // R10: an abort releases chip select and ends the transaction
    a_r10_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stop |=> (spi_cs_n && !busy));

    // R5: the serial clock stays low whenever no transaction runs
    a_r5_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !spi_sclk);

    // R4: no lane is driven outside a transaction
    a_r4_lanes_released_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (spi_io_oe == 4'b0000));

    // R1: done only appears once the chain has finished
    a_r1_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_done) |-> !busy);

    // R9: a program error ends the transaction with chip select released
    a_r9_perr_ends: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_perr) |-> (spi_cs_n && !busy));

    // R6: chip select rises only when a transaction ends
    a_r6_cs_rise_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> !busy);

    // R11: a clear empties both FIFOs
    a_r11_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_fifo_clr |=> (tx_empty && rx_empty));

endmodule

bind spi_desc_master spi_desc_master_chk u_chk (.*);

// File: tb/spi_desc_master_bench.sv
`timescale 1ns/1ps
module spi_desc_master_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        desc_we = 1'b0;
    logic [3:0]  desc_idx = '0;
    logic [26:0] desc_wdata = '0;
    logic [7:0]  clk_div = '0;
    logic [1:0]  irq_en = '0;
    logic        cmd_start = 1'b0, cmd_stop = 1'b0, cmd_fifo_clr = 1'b0;
    logic [1:0]  sts_clr = '0;
    logic        tx_wr = 1'b0;
    logic [7:0]  tx_wdata = '0;
    logic        rx_rd = 1'b0;
    logic        tx_full, tx_empty, tx_dreq, rx_empty, rx_dreq;
    logic [7:0]  rx_rdata;
    logic        busy, sts_done, sts_perr, irq;
    logic        spi_sclk, spi_cs_n;
    logic [3:0]  spi_io_out, spi_io_oe, spi_io_in;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    spi_desc_master u_spi_desc_master (
        .clk(clk), .rst_n(rst_n), .desc_we(desc_we), .desc_idx(desc_idx),
        .desc_wdata(desc_wdata), .clk_div(clk_div), .irq_en(irq_en),
        .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_fifo_clr(cmd_fifo_clr),
        .sts_clr(sts_clr), .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_full(tx_full),
        .tx_empty(tx_empty), .tx_dreq(tx_dreq), .rx_rd(rx_rd), .rx_rdata(rx_rdata),
        .rx_empty(rx_empty), .rx_dreq(rx_dreq), .busy(busy), .sts_done(sts_done),
        .sts_perr(sts_perr), .irq(irq), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_io_out(spi_io_out), .spi_io_oe(spi_io_oe), .spi_io_in(spi_io_in)
    );

    // Serial-side model: captures driven bytes, answers with response bytes
    int         mon_lanes = 1;
    int         rises = 0, oe0_rises = 0, cap_cnt = 0, cap_n = 0, resp_pos = 0;
    logic [7:0] cap_sh = '0;
    logic [7:0] cap [64];
    logic [7:0] resp [64];
    time        rise_time [256];
    logic [7:0] rb, rsh;

    always @(posedge spi_sclk or posedge spi_cs_n) begin
        if (spi_cs_n) begin
            cap_n = 0;
        end else begin
            rise_time[rises % 256] = $time;
            rises++;
            if (spi_io_oe != 4'b0000) begin
                case (mon_lanes)
                    1:       cap_sh = {cap_sh[6:0], spi_io_out[0]};
                    2:       cap_sh = {cap_sh[5:0], spi_io_out[1:0]};
                    default: cap_sh = {cap_sh[3:0], spi_io_out[3:0]};
                endcase
                cap_n += mon_lanes;
                if (cap_n >= 8) begin
                    cap[cap_cnt % 64] = cap_sh;
                    cap_cnt++;
                    cap_n = 0;
                end
            end else begin
                oe0_rises++;
                resp_pos += mon_lanes;
            end
        end
    end

    always_comb begin
        rb  = resp[(resp_pos / 8) % 64];
        rsh = rb << (resp_pos % 8);
        case (mon_lanes)
            1:       spi_io_in = {2'b00, rsh[7], 1'b0};
            2:       spi_io_in = {2'b00, rsh[7:6]};
            default: spi_io_in = rsh[7:4];
        endcase
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [26:0] mk(input logic [1:0] lanes, input bit tx, input bit rx,
                                       input logic [1:0] us, input logic [14:0] units,
                                       input logic [3:0] nxt, input bit last, input bit cls);
        return {cls, last, nxt, units, us, rx, tx, lanes};
    endfunction

    task automatic wr_desc(input logic [3:0] idx, input logic [26:0] w);
        desc_we = 1'b1; desc_idx = idx; desc_wdata = w;
        @(negedge clk);
        desc_we = 1'b0;
    endtask

    task automatic push_tx(input logic [7:0] b);
        tx_wr = 1'b1; tx_wdata = b;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic pop_rx(output logic [7:0] b);
        b = rx_rdata; rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
    endtask

    task automatic pulse_start();
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic clear_sts();
        sts_clr = 2'b11;
        @(negedge clk);
        sts_clr = 2'b00;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(spi_cs_n == 1'b1, "R6 reset cs_n", spi_cs_n, 1);
        chk(spi_sclk == 1'b0, "R5 reset sclk", spi_sclk, 0);
        chk(sts_done == 1'b0 && busy == 1'b0, "R1 reset done/busy", {sts_done, busy}, 0);
        chk(tx_empty && rx_empty, "R11 reset fifos empty", {tx_empty, rx_empty}, 3);
        chk(irq == 1'b0, "R13 reset irq", irq, 0);
    endtask

    task automatic t_chain_single();
        int cb = cap_cnt; int rb0 = rises;
        wr_desc(0, mk(2'd0, 1, 0, 2'd0, 15'd2, 4'd5, 0, 0));
        wr_desc(1, mk(2'd3, 1, 0, 2'd0, 15'd1, 4'd0, 1, 1));
        wr_desc(5, mk(2'd0, 1, 0, 2'd0, 15'd1, 4'd0, 1, 1));
        push_tx(8'hA5); push_tx(8'h3C); push_tx(8'h81);
        clk_div = 8'd2; mon_lanes = 1;
        pulse_start();
        chk(spi_cs_n == 1'b0, "R6 cs asserted at start", spi_cs_n, 0);
        repeat (20) @(negedge clk);
        chk(sts_done == 1'b0, "R1 no done mid-chain", sts_done, 0);
        wait_idle();
        chk(cap[cb % 64] == 8'hA5, "R2 single-lane byte0", cap[cb % 64], 8'hA5);
        chk(cap[(cb + 1) % 64] == 8'h3C, "R2 single-lane byte1", cap[(cb + 1) % 64], 8'h3C);
        chk(cap[(cb + 2) % 64] == 8'h81, "R1 chain reaches entry 5", cap[(cb + 2) % 64], 8'h81);
        chk(rises - rb0 == 24, "R3 clock count", rises - rb0, 24);
        chk(sts_done && !sts_perr, "R1 done, entry 1 skipped", {sts_done, sts_perr}, 2);
        chk(spi_cs_n == 1'b1, "R6 close releases cs", spi_cs_n, 1);
        chk(rise_time[(rb0 + 1) % 256] - rise_time[rb0 % 256] == 48, "R5 period div2",
            int'(rise_time[(rb0 + 1) % 256] - rise_time[rb0 % 256]), 48);
        clear_sts();
    endtask

    task automatic t_quad_units();
        int cb = cap_cnt; int rb0 = rises;
        wr_desc(0, mk(2'd2, 1, 0, 2'd1, 15'd1, 4'd0, 1, 1));
        push_tx(8'h12); push_tx(8'h34); push_tx(8'hA5); push_tx(8'hF0);
        clk_div = 8'd0; mon_lanes = 4;
        pulse_start();
        wait_idle();
        chk(cap[cb % 64] == 8'h12, "R2 quad byte0", cap[cb % 64], 8'h12);
        chk(cap[(cb + 3) % 64] == 8'hF0, "R2 quad byte3", cap[(cb + 3) % 64], 8'hF0);
        chk(rises - rb0 == 8, "R3 four-byte unit at x4", rises - rb0, 8);
        clear_sts();
    endtask

    task automatic t_dual_dummy();
        int cb = cap_cnt; int rb0 = rises; int ob = oe0_rises; int base = resp_pos / 8;
        resp[base % 64] = 8'h00; resp[(base + 1) % 64] = 8'h00; resp[(base + 2) % 64] = 8'hB7;
        wr_desc(0, mk(2'd1, 1, 0, 2'd0, 15'd1, 4'd1, 0, 0));
        wr_desc(1, mk(2'd1, 0, 0, 2'd0, 15'd2, 4'd2, 0, 0));
        wr_desc(2, mk(2'd1, 0, 1, 2'd0, 15'd1, 4'd0, 1, 1));
        push_tx(8'h6D);
        clk_div = 8'd1; mon_lanes = 2;
        pulse_start();
        wait_idle();
        chk(cap[cb % 64] == 8'h6D, "R2 dual tx byte", cap[cb % 64], 8'h6D);
        chk(rises - rb0 == 16, "R4 total clocks incl dummy", rises - rb0, 16);
        chk(oe0_rises - ob == 12, "R4 undriven clocks", oe0_rises - ob, 12);
        chk(!rx_empty && rx_rdata == 8'hB7, "R2 dual rx byte", rx_rdata, 8'hB7);
        clear_sts();
    endtask

    task automatic t_stop_flush();
        wr_desc(0, mk(2'd0, 1, 0, 2'd0, 15'd4, 4'd0, 1, 0));
        push_tx(8'h11); push_tx(8'h22); push_tx(8'h33); push_tx(8'h44);
        clk_div = 8'd3; mon_lanes = 1;
        pulse_start();
        repeat (30) @(negedge clk);
        cmd_stop = 1'b1;
        @(negedge clk);
        cmd_stop = 1'b0;
        chk(spi_cs_n && !busy, "R10 stop releases", {spi_cs_n, busy}, 2);
        chk(sts_done == 1'b0, "R10 no done after stop", sts_done, 0);
        chk(tx_empty == 1'b0 && rx_empty == 1'b0, "R11 fifos hold data", {tx_empty, rx_empty}, 0);
        cmd_fifo_clr = 1'b1;
        @(negedge clk);
        cmd_fifo_clr = 1'b0;
        chk(tx_empty && rx_empty, "R11 clear empties both", {tx_empty, rx_empty}, 3);
        chk(tx_dreq && !rx_dreq, "R11 request levels", {tx_dreq, rx_dreq}, 2);
        clear_sts();
    endtask

    task automatic t_no_close();
        int cb = cap_cnt;
        wr_desc(0, mk(2'd0, 1, 0, 2'd0, 15'd1, 4'd0, 1, 0));
        push_tx(8'h5A);
        clk_div = 8'd0; mon_lanes = 1;
        pulse_start();
        wait_idle();
        chk(spi_cs_n == 1'b0 && sts_done, "R6 cs held without close", {spi_cs_n, sts_done}, 1);
        chk(cap[cb % 64] == 8'h5A, "R2 byte without close", cap[cb % 64], 8'h5A);
        cmd_stop = 1'b1;
        @(negedge clk);
        cmd_stop = 1'b0;
        chk(spi_cs_n == 1'b1, "R10 stop releases held cs", spi_cs_n, 1);
        clear_sts();
    endtask

    task automatic t_tx_stall();
        int cb = cap_cnt; int rb0 = rises; logic [7:0] e;
        wr_desc(0, mk(2'd0, 1, 0, 2'd2, 15'd1, 4'd0, 1, 1));
        for (int i = 0; i < 8; i++) push_tx(8'(i * 13 + 5));
        clk_div = 8'd0; mon_lanes = 1;
        pulse_start();
        repeat (300) @(negedge clk);
        chk(busy && !spi_sclk && !spi_cs_n, "R7 stalled with clock low", {busy, spi_sclk, spi_cs_n}, 4);
        chk(rises - rb0 == 64, "R7 clocks stop at empty FIFO", rises - rb0, 64);
        chk(sts_done == 1'b0, "R1 no done while stalled", sts_done, 0);
        for (int i = 8; i < 16; i++) push_tx(8'(i * 13 + 5));
        wait_idle();
        chk(rises - rb0 == 128, "R3 sixteen-byte unit", rises - rb0, 128);
        e = 8'(15 * 13 + 5);
        chk(cap[(cb + 15) % 64] == e, "R7 last byte after resume", cap[(cb + 15) % 64], e);
        clear_sts();
    endtask

    task automatic t_rx_stall();
        int rb0 = rises; int base = resp_pos / 8; logic [7:0] v; logic [7:0] e;
        for (int i = 0; i < 16; i++) resp[(base + i) % 64] = 8'(i * 7 + 1);
        wr_desc(0, mk(2'd0, 0, 1, 2'd2, 15'd1, 4'd0, 1, 1));
        clk_div = 8'd0; mon_lanes = 1;
        pulse_start();
        repeat (300) @(negedge clk);
        chk(busy && !spi_sclk, "R8 stalled on full RX", {busy, spi_sclk}, 2);
        chk(rises - rb0 == 64, "R8 clocks stop at full FIFO", rises - rb0, 64);
        for (int i = 0; i < 8; i++) begin
            pop_rx(v); e = 8'(i * 7 + 1);
            if (i == 0 || i == 7) chk(v == e, "R8 rx byte before resume", v, e);
        end
        wait_idle();
        chk(rises - rb0 == 128, "R8 resumes to completion", rises - rb0, 128);
        for (int i = 8; i < 16; i++) begin
            pop_rx(v); e = 8'(i * 7 + 1);
            if (i == 15) chk(v == e, "R8 last rx byte", v, e);
        end
        clear_sts();
    endtask

    task automatic t_perr_race();
        wr_desc(0, mk(2'd3, 1, 0, 2'd0, 15'd1, 4'd0, 1, 1));
        pulse_start();
        sts_clr = 2'b10;
        @(negedge clk);
        sts_clr = 2'b00;
        chk(sts_perr == 1'b1, "R12 set wins over clear", sts_perr, 1);
        chk(spi_cs_n && !busy && !sts_done, "R9 bad lane code ends", {spi_cs_n, busy, sts_done}, 4);
        sts_clr = 2'b10;
        @(negedge clk);
        sts_clr = 2'b00;
        chk(sts_perr == 1'b0, "R12 write-1 clear", sts_perr, 0);
    endtask

    task automatic t_irq();
        clear_sts();
        irq_en = 2'b11;
        @(negedge clk);
        chk(irq == 1'b0, "R13 no irq without status", irq, 0);
        wr_desc(0, mk(2'd0, 1, 0, 2'd0, 15'd1, 4'd0, 1, 1));
        push_tx(8'hC3);
        pulse_start();
        wait_idle();
        irq_en = 2'b00; @(negedge clk);
        chk(irq == 1'b0, "R13 done masked", irq, 0);
        irq_en = 2'b01; @(negedge clk);
        chk(irq == 1'b1, "R13 done enabled", irq, 1);
        irq_en = 2'b10; @(negedge clk);
        chk(irq == 1'b0, "R13 perr enable alone", irq, 0);
        clear_sts();
        wr_desc(0, mk(2'd0, 1, 0, 2'd3, 15'd1, 4'd0, 1, 1));
        pulse_start();
        repeat (3) @(negedge clk);
        chk(sts_perr && !sts_done, "R9 bad unit code", {sts_perr, sts_done}, 2);
        chk(irq == 1'b1, "R13 perr enabled", irq, 1);
        clear_sts();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) begin resp[i] = 8'h00; cap[i] = 8'h00; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_chain_single();
        t_quad_units();
        t_dual_dummy();
        t_stop_flush();
        t_no_close();
        t_tx_stall();
        t_rx_stall();
        t_perr_race();
        t_irq();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule